// File: doc/BRIEF.md
# Time Code Frame Validator

This block checks one captured minute frame of a longwave radio time signal and turns it into calendar time. A capture stage upstream presents all 59 frame bits in parallel and pulses a strobe once the minute is complete. The validator tests the start-of-time bit and three even-parity groups. It decodes six packed-BCD fields and range-checks each of them. One cycle later it reports the result on registered outputs, together with a one-cycle done pulse.

The field outputs only change when a frame passes every check. A frame that fails leaves the last good time on the outputs and clears the valid flag. A consumer can therefore keep running from the most recent good minute while the receiver recovers.

Top module: `tcv_frame_validator`

## Requirements
- R1: `done_o` is high in the cycle after each cycle in which `strobe_i` is high, and is low otherwise.
- R2: A frame of all zeros gives `valid_o` = 0.
- R3: Frame bit 20 must be 1, or the frame is invalid.
- R4: Bits 21 to 28 must hold an even number of ones, or the frame is invalid.
- R5: Bits 29 to 35 must hold an even number of ones, or the frame is invalid.
- R6: Bits 36 to 58 must hold an even number of ones, or the frame is invalid.
- R7: Minutes come from bits 21..27, weighted 1,2,4,8,10,20,40. A value above 59 is invalid.
- R8: Hours come from bits 29..34, weighted 1,2,4,8,10,20. A value above 23 is invalid.
- R9: Day of month comes from bits 36..41, weighted 1,2,4,8,10,20. It must lie in 1..31.
- R10: Weekday comes from bits 42..44, weighted 1,2,4. It must lie in 1..7, where 1 is Monday.
- R11: Month comes from bits 45..49, weighted 1,2,4,8,10. It must lie in 1..12.
- R12: Year of century comes from bits 50..57, weighted 1,2,4,8,10,20,40,80. It must be at most 99.
- R13: A units digit (the lowest four bits of any field that has four) above 9 makes the frame invalid.
- R14: After reset all outputs are 0. `valid_o` is updated on every strobe. The field outputs take new values only from a valid frame and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 59 | Captured minute frame, bit n = second n |
| strobe_i | input | 1 | Frame complete, one cycle |
| minute_o | output | 7 | Minutes 0..59 |
| hour_o | output | 5 | Hours 0..23 |
| mday_o | output | 5 | Day of month 1..31 |
| wday_o | output | 3 | Weekday 1..7 |
| month_o | output | 4 | Month 1..12 |
| year_o | output | 7 | Year of century 0..99 |
| valid_o | output | 1 | Last strobed frame passed all checks |
| done_o | output | 1 | Result updated this cycle |

## Verification
A strobe can land in the same cycle as the done pulse of the previous frame, so the capture of a new result and the report of the previous one overlap. The bench provokes this by holding the strobe high for two cycles: a valid frame is followed directly by one with a broken date parity. It judges each result at its own cycle. The first cycle must show the good time with valid set. The second must keep done high, clear valid and leave the fields at the first frame's values.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int FRAME_W   = 59;
  localparam int START_BIT = 20;
  localparam int N_GRP     = 3;
  // even-parity groups, parity bit is the top of each range
  localparam int GRP_LO [N_GRP] = '{21, 29, 36};
  localparam int GRP_HI [N_GRP] = '{28, 35, 58};
endpackage

// File: rtl/tcv_parity.sv
module tcv_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_i,
  output logic         even_o
);
  assign even_o = ~(^bits_i);
endmodule

// File: rtl/tcv_bcd_field.sv
module tcv_bcd_field #(
  parameter int UNITS_W = 4,
  parameter int TENS_W  = 3,
  parameter int MIN_V   = 0,
  parameter int MAX_V   = 59,
  parameter int VAL_W   = 7
) (
  input  logic [UNITS_W+TENS_W-1:0] raw_i,
  output logic [VAL_W-1:0]          val_o,
  output logic                      ok_o
);
  localparam int SUM_W = 8;

  logic [SUM_W-1:0] units, tens, sum;
  logic             digit_ok;

  assign units = SUM_W'(raw_i[UNITS_W-1:0]);

  generate
    if (TENS_W > 0) begin : g_tens
      assign tens = SUM_W'(raw_i[UNITS_W+TENS_W-1:UNITS_W]);
    end else begin : g_no_tens
      assign tens = '0;
    end
    if (UNITS_W >= 4) begin : g_digit
      assign digit_ok = (units <= SUM_W'(9));
    end else begin : g_no_digit
      assign digit_ok = 1'b1;
    end
  endgenerate

  assign sum   = units + SUM_W'(tens * SUM_W'(10));
  assign val_o = sum[VAL_W-1:0];
  assign ok_o  = digit_ok && (sum >= SUM_W'(MIN_V)) && (sum <= SUM_W'(MAX_V));
endmodule

// File: rtl/tcv_frame_validator.sv
module tcv_frame_validator
  import tcv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               strobe_i,
  output logic [6:0]         minute_o,
  output logic [4:0]         hour_o,
  output logic [4:0]         mday_o,
  output logic [2:0]         wday_o,
  output logic [3:0]         month_o,
  output logic [6:0]         year_o,
  output logic               valid_o,
  output logic               done_o
);
  logic [N_GRP-1:0] par_ok;

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_par
      localparam int LO = GRP_LO[g];
      localparam int HI = GRP_HI[g];
      tcv_parity #(.W(HI-LO+1)) u_par (
        .bits_i (frame_i[HI:LO]),
        .even_o (par_ok[g])
      );
    end
  endgenerate

  logic [6:0] min_d, yr_d;
  logic [4:0] hr_d, day_d;
  logic [2:0] wd_d;
  logic [3:0] mon_d;
  logic       min_ok, hr_ok, day_ok, wd_ok, mon_ok, yr_ok;

  tcv_bcd_field #(.UNITS_W(4), .TENS_W(3), .MIN_V(0), .MAX_V(59), .VAL_W(7)) u_min (
    .raw_i(frame_i[27:21]), .val_o(min_d), .ok_o(min_ok));
  tcv_bcd_field #(.UNITS_W(4), .TENS_W(2), .MIN_V(0), .MAX_V(23), .VAL_W(5)) u_hr (
    .raw_i(frame_i[34:29]), .val_o(hr_d), .ok_o(hr_ok));
  tcv_bcd_field #(.UNITS_W(4), .TENS_W(2), .MIN_V(1), .MAX_V(31), .VAL_W(5)) u_day (
    .raw_i(frame_i[41:36]), .val_o(day_d), .ok_o(day_ok));
  tcv_bcd_field #(.UNITS_W(3), .TENS_W(0), .MIN_V(1), .MAX_V(7), .VAL_W(3)) u_wd (
    .raw_i(frame_i[44:42]), .val_o(wd_d), .ok_o(wd_ok));
  tcv_bcd_field #(.UNITS_W(4), .TENS_W(1), .MIN_V(1), .MAX_V(12), .VAL_W(4)) u_mon (
    .raw_i(frame_i[49:45]), .val_o(mon_d), .ok_o(mon_ok));
  tcv_bcd_field #(.UNITS_W(4), .TENS_W(4), .MIN_V(0), .MAX_V(99), .VAL_W(7)) u_yr (
    .raw_i(frame_i[57:50]), .val_o(yr_d), .ok_o(yr_ok));

  logic frame_ok;
  assign frame_ok = (|frame_i) && frame_i[START_BIT] && (&par_ok) &&
                    min_ok && hr_ok && day_ok && wd_ok && mon_ok && yr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
      minute_o <= '0;
      hour_o   <= '0;
      mday_o   <= '0;
      wday_o   <= '0;
      month_o  <= '0;
      year_o   <= '0;
    end else begin
      done_o <= strobe_i;
      if (strobe_i) begin
        valid_o <= frame_ok;
        if (frame_ok) begin
          minute_o <= min_d;
          hour_o   <= hr_d;
          mday_o   <= day_d;
          wday_o   <= wd_d;
          month_o  <= mon_d;
          year_o   <= yr_d;
        end
      end
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> done_o);
  // R1
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !done_o);
  // R2
  zero_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && frame_i == '0) |=> !valid_o);
  // R3
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !frame_i[START_BIT]) |=> !valid_o);
  // R14
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable({minute_o, hour_o, mday_o, wday_o, month_o, year_o, valid_o}));
  // R7
  minute_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> minute_o <= 7'd59);
  // R8
  hour_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> hour_o <= 5'd23);
  // R11
  month_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (month_o >= 4'd1 && month_o <= 4'd12));
endmodule

// File: tb/tb_tcv_frame_validator.sv
module tb_tcv_frame_validator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [58:0] frame_i = '0;
  logic        strobe_i = 1'b0;
  logic [6:0]  minute_o, year_o;
  logic [4:0]  hour_o, mday_o;
  logic [2:0]  wday_o;
  logic [3:0]  month_o;
  logic        valid_o, done_o;

  int n_chk = 0, n_fail = 0;
  int h_min = 0, h_hr = 0, h_day = 0, h_wd = 0, h_mon = 0, h_yr = 0;

  always #2 clk_i = ~clk_i;

  tcv_frame_validator dut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  function automatic logic [58:0] fix_par(logic [58:0] f);
    logic [58:0] r = f;
    r[28] = ^f[27:21];
    r[35] = ^f[34:29];
    r[58] = ^f[57:36];
    return r;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [58:0] encode(int m, int h, int d, int w, int mo, int y);
    logic [58:0] f = '0;
    logic [7:0] b;
    f[20] = 1'b1;
    b = bcd(m);  f[27:21] = b[6:0];
    b = bcd(h);  f[34:29] = b[5:0];
    b = bcd(d);  f[41:36] = b[5:0];
    f[44:42] = 3'(w);
    b = bcd(mo); f[49:45] = b[4:0];
    b = bcd(y);  f[57:50] = b;
    return fix_par(f);
  endfunction

  function automatic bit exp_ok(logic [58:0] f);
    int v, u;
    if (f == '0) return 0;
    if (!f[20]) return 0;
    if (^f[28:21] || ^f[35:29] || ^f[58:36]) return 0;
    u = int'(f[24:21]); v = u + 10 * int'(f[27:25]);
    if (u > 9 || v > 59) return 0;
    u = int'(f[32:29]); v = u + 10 * int'(f[34:33]);
    if (u > 9 || v > 23) return 0;
    u = int'(f[39:36]); v = u + 10 * int'(f[41:40]);
    if (u > 9 || v < 1 || v > 31) return 0;
    if (f[44:42] == 3'd0) return 0;
    u = int'(f[48:45]); v = u + 10 * int'(f[49]);
    if (u > 9 || v < 1 || v > 12) return 0;
    u = int'(f[53:50]); v = u + 10 * int'(f[57:54]);
    if (u > 9 || v > 99) return 0;
    return 1;
  endfunction

  task automatic update_model(logic [58:0] f);
    if (exp_ok(f)) begin
      h_min = int'(f[24:21]) + 10 * int'(f[27:25]);
      h_hr  = int'(f[32:29]) + 10 * int'(f[34:33]);
      h_day = int'(f[39:36]) + 10 * int'(f[41:40]);
      h_wd  = int'(f[44:42]);
      h_mon = int'(f[48:45]) + 10 * int'(f[49]);
      h_yr  = int'(f[53:50]) + 10 * int'(f[57:54]);
    end
  endtask

  task automatic check_result(logic [58:0] f, string req);
    bit e = exp_ok(f);
    chk(done_o == 1'b1, "R1", int'(done_o), 1);
    chk(valid_o == e, req, int'(valid_o), int'(e));
    chk(int'(minute_o) == h_min, e ? "R7"  : "R14", int'(minute_o), h_min);
    chk(int'(hour_o)   == h_hr,  e ? "R8"  : "R14", int'(hour_o),   h_hr);
    chk(int'(mday_o)   == h_day, e ? "R9"  : "R14", int'(mday_o),   h_day);
    chk(int'(wday_o)   == h_wd,  e ? "R10" : "R14", int'(wday_o),   h_wd);
    chk(int'(month_o)  == h_mon, e ? "R11" : "R14", int'(month_o),  h_mon);
    chk(int'(year_o)   == h_yr,  e ? "R12" : "R14", int'(year_o),   h_yr);
  endtask

  task automatic apply(logic [58:0] f, string req);
    @(negedge clk_i);
    frame_i = f; strobe_i = 1'b1;
    update_model(f);
    @(negedge clk_i);
    strobe_i = 1'b0;
    check_result(f, req);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
  endtask

  task automatic sweep(int lo, int w, string req);
    logic [58:0] base = encode(30, 12, 15, 3, 6, 24);
    for (int r = 0; r < (1 << w); r++) begin
      logic [58:0] f = base;
      for (int b = 0; b < w; b++) f[lo + b] = 1'(r >> b);
      apply(fix_par(f), req);
    end
  endtask

  initial begin
    logic [58:0] good, bad;
    repeat (3) @(negedge clk_i);
    // R14 reset state
    chk(done_o == 0 && valid_o == 0, "R14", int'(valid_o), 0);
    chk({minute_o, hour_o, mday_o, wday_o, month_o, year_o} == '0, "R14",
        int'(minute_o), 0);
    rst_ni = 1'b1;

    good = encode(59, 23, 31, 7, 12, 99);
    apply(good, "R7");
    apply(encode(0, 0, 1, 1, 1, 0), "R12");
    apply('0, "R2");                               // R2 zero frame, fields hold
    bad = good; bad[20] = 1'b0;
    apply(bad, "R3");                              // R3
    apply(good, "R3");
    bad = good; bad[28] = ~bad[28];
    apply(bad, "R4");                              // R4
    bad = good; bad[35] = ~bad[35];
    apply(bad, "R5");                              // R5
    bad = good; bad[58] = ~bad[58];
    apply(bad, "R6");                              // R6
    bad = good; bad[47] = ~bad[47];
    apply(bad, "R6");
    // near-exhaustive raw sweeps; R13 digit > 9 covered in each
    sweep(21, 7, "R7");
    sweep(29, 6, "R8");
    sweep(36, 6, "R9");
    sweep(42, 3, "R10");
    sweep(45, 5, "R11");
    sweep(50, 8, "R12");
    apply(encode(15, 9, 9, 2, 9, 9) ^ (59'd1 << 24), "R13");

    // R1/R14 back-to-back strobes
    good = encode(42, 17, 28, 5, 2, 37);
    bad = encode(1, 2, 3, 4, 5, 6); bad[58] = ~bad[58];
    @(negedge clk_i);
    frame_i = good; strobe_i = 1'b1;
    update_model(good);
    @(negedge clk_i);
    check_result(good, "R1");
    frame_i = bad;
    update_model(bad);
    @(negedge clk_i);
    strobe_i = 1'b0;
    check_result(bad, "R14");
    @(negedge clk_i);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    summary();
  end
endmodule